// File: doc/BRIEF.md
# Clock Synthesizer Power-Up Programmer

This block brings an external three-output PLL clock synthesizer into a known frequency plan over a two-wire bus. A one-cycle `start` pulse launches a fixed series of write transactions. The block drives the open-drain clock and data lines through active-high "pull low" outputs and reads the wired data line back for acknowledge. When the last write completes it raises `done`. If any byte is not acknowledged, it releases the bus with a stop condition and raises `error`.

The byte table lives in 22 internal registers. Reset loads them from parameters: the feedback multiplier and the output-0 divider are turned into integer-mode parameter bytes. While the sequencer is idle, the load port can overwrite any table byte, so output 0 can be retuned before the next `start`. Every transaction begins with the write address byte. The register address follows, then a burst of data bytes, because the slave advances its register pointer after each byte.

Top module: `clksyn_i2c_init`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low and both bus lines are released. Whenever `busy` is low, both lines stay released.
- R2: Each transaction is framed as follows: a start condition, the byte 0xC0, a register address, one or more data bytes, and a stop condition. Each byte is sent MSB first and followed by one acknowledge clock.
- R3: A full run performs exactly four transactions, at register addresses 0x1A, 0x2A, 0xB1 and 0x10, in that order. The PLL reset therefore comes after both divider blocks.
- R4: With default parameters (multiplier 32, divider 4), the run writes the following. Registers 0x1A..0x21 receive 00 01 00 0E 00 00 00 00. Registers 0x2A..0x31 receive 00 01 0C 00 00 00 00 00, where 0x0C sets both divide-by-4 bits [3:2] of the third block byte with P1 = 0. Register 0xB1 receives 0x20 and register 0x10 receives 0x4F.
- R5: An integer divider N is encoded as P1 = 128*N − 512. In each 8-byte block, P1[17:16] sits in bits [1:0] of byte 2, P1[15:8] fills byte 3 and P1[7:0] fills byte 4. Bytes 0..1 carry P3 = 1 and the rest are zero.
- R6: A `load_we` pulse while idle replaces table byte `load_idx`, and every later run sends the new byte. The table is in transmit order: index 0 is the 0x1A address, indices 1..8 are its block, index 9 is the 0x2A address, indices 10..17 are its block, indices 18..19 are the reset write and indices 20..21 are the output-control write. Loads while `busy` is high have no effect.
- R7: Within a transaction, every SCL high pulse lasts exactly 2*QTR_CYCLES clocks. SDA changes while SCL is high only to form a start or a stop condition.
- R8: If any byte gets no acknowledge, the block ends that transaction with a stop and starts no further transaction, so the PLL reset is not written. It then drops `busy` and raises `error` with `done` low.
- R9: `busy` rises in the cycle after an accepted `start` and stays high until the run ends. A `start` while busy is ignored. `done` and `error` hold until the next accepted `start` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a programming run |
| load_we | input | 1 | Table byte write strobe (honoured only when idle) |
| load_idx | input | 5 | Table byte index, 0..21 |
| load_byte | input | 8 | New table byte value |
| sda_in | input | 1 | Sensed level of the wired SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed, all bytes acknowledged |
| error | output | 1 | Last run aborted on a missing acknowledge |

## Verification
The hardest condition to reach from the ports is an acknowledge that goes missing partway through a run, after some registers are already written and before the PLL reset. The bench slave model is told which byte of the run, counted from zero across all transactions, to leave unacknowledged. One run refuses the address phase of the third transaction and another refuses a data byte inside the first burst. In both, the recorded register image shows exactly where writing stopped. A further run injects a table load and a second `start` while the bus is active, to show that both are ignored.

// File: rtl/clksyn_pkg.sv
// Shared types and table construction for the clock synthesizer programmer.
// Assumes the fixed four-transaction layout described in the brief.
package clksyn_pkg;

    localparam int          TBL_LEN = 22;
    localparam int          IDX_W   = $clog2(TBL_LEN);
    localparam logic [7:0]  DEV_WR  = 8'hC0;

    typedef enum logic [1:0] {BC_START, BC_WRITE, BC_STOP} bus_cmd_t;

    // Integer-mode divider parameter for a ratio n.
    function automatic logic [17:0] int_p1(input int n);
        return 18'(128 * n - 512);
    endfunction

    // Reset content of table entry idx for the given multiplier and divider.
    function automatic logic [7:0] tbl_default(input int idx, input int fb_mult, input int out_div);
        logic [17:0] pf;
        logic [17:0] po;
        logic [1:0]  d4;
        logic [7:0]  b;
        pf = int_p1(fb_mult);
        po = (out_div == 4) ? 18'd0 : int_p1(out_div);
        d4 = (out_div == 4) ? 2'b11 : 2'b00;
        case (idx)
            0:       b = 8'h1A;
            2, 11:   b = 8'h01;
            3:       b = {6'd0, pf[17:16]};
            4:       b = pf[15:8];
            5:       b = pf[7:0];
            9:       b = 8'h2A;
            12:      b = {4'd0, d4, po[17:16]};
            13:      b = po[15:8];
            14:      b = po[7:0];
            18:      b = 8'hB1;
            19:      b = 8'h20;
            20:      b = 8'h10;
            21:      b = 8'h4F;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    // True for the final data byte of a transaction.
    function automatic logic is_last(input int idx);
        return (idx == 8) || (idx == 17) || (idx == 19) || (idx == 21);
    endfunction

endpackage

// File: rtl/clksyn_cfg_table.sv
// Register-file table holding every register address and data byte in send order.
// Reset loads computed defaults; software-free load port writes one byte when unlocked.
module clksyn_cfg_table
    import clksyn_pkg::*;
#(
    parameter int FB_MULT = 32,
    parameter int OUT_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             load_we,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [7:0]       load_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    logic [7:0] mem [TBL_LEN];

    // Reset to defaults, or take a load while the sequencer is idle.
    always_ff @(posedge clk) begin : p_store
        for (int i = 0; i < TBL_LEN; i++) begin
            if (!rst_n)
                mem[i] <= tbl_default(i, FB_MULT, OUT_DIV);
            else if (load_we && !lock && load_idx == IDX_W'(i))
                mem[i] <= load_byte;
        end
    end

    // Read mux; indices past the end return zero.
    always_comb begin : p_read
        rd_byte = (rd_idx < IDX_W'(TBL_LEN)) ? mem[rd_idx] : 8'h00;
    end

    for (genvar g = 0; g < TBL_LEN; g++) begin : g_guard
        assert_table_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lock |=> $stable(mem[g]));
    end

endmodule

// File: rtl/clksyn_bit_engine.sv
// Bit-level bus master: performs one start, byte write (with ACK sample) or stop per command.
// Every operation spans four quarter-periods of QTR_CYCLES clocks; no clock stretching.
module clksyn_bit_engine
    import clksyn_pkg::*;
#(
    parameter int QTR_CYCLES = 63
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  bus_cmd_t cmd,
    input  logic [7:0] cmd_byte,
    input  logic     sda_in,
    output logic     done,
    output logic     nack,
    output logic     scl_lo,
    output logic     sda_lo
);
    localparam int DIV_W = $clog2(QTR_CYCLES + 1);

    typedef enum logic [1:0] {E_IDLE, E_START, E_BIT, E_STOP} eng_st_t;

    eng_st_t          st;
    logic [DIV_W-1:0] divcnt;
    logic [1:0]       qcnt;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic             tick;

    // Quarter-period strobe.
    always_comb begin : p_tick
        tick = (divcnt == DIV_W'(QTR_CYCLES - 1));
    end

    // Step the active operation; line levels change only on quarter boundaries.
    always_ff @(posedge clk) begin : p_engine
        if (!rst_n) begin
            st     <= E_IDLE;
            divcnt <= '0;
            qcnt   <= '0;
            bitcnt <= '0;
            shreg  <= '0;
            nack   <= 1'b0;
            done   <= 1'b0;
            scl_lo <= 1'b0;
            sda_lo <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == E_IDLE) begin
                divcnt <= '0;
                qcnt   <= '0;
                if (cmd_valid) begin
                    bitcnt <= '0;
                    shreg  <= cmd_byte;
                    case (cmd)
                        BC_START: st <= E_START;
                        BC_WRITE: begin st <= E_BIT; nack <= 1'b0; end
                        default:  st <= E_STOP;
                    endcase
                end
            end else if (!tick) begin
                divcnt <= divcnt + 1'b1;
            end else begin
                divcnt <= '0;
                qcnt   <= qcnt + 1'b1;
                case (st)
                    E_START: case (qcnt)
                        2'd0:    sda_lo <= 1'b1;
                        2'd1:    scl_lo <= 1'b1;
                        2'd3:    begin st <= E_IDLE; done <= 1'b1; end
                        default: ;
                    endcase
                    E_BIT: case (qcnt)
                        2'd0: sda_lo <= (bitcnt == 4'd8) ? 1'b0 : ~shreg[7];
                        2'd1: scl_lo <= 1'b0;
                        2'd2: if (bitcnt == 4'd8) nack <= sda_in;
                        2'd3: begin
                            scl_lo <= 1'b1;
                            if (bitcnt == 4'd8) begin
                                st   <= E_IDLE;
                                done <= 1'b1;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                shreg  <= {shreg[6:0], 1'b0};
                            end
                        end
                    endcase
                    E_STOP: case (qcnt)
                        2'd0: sda_lo <= 1'b1;
                        2'd1: scl_lo <= 1'b0;
                        2'd2: sda_lo <= 1'b0;
                        2'd3: begin st <= E_IDLE; done <= 1'b1; end
                    endcase
                    default: st <= E_IDLE;
                endcase
            end
        end
    end

    assert_sda_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_lo && !$past(scl_lo) && (sda_lo != $past(sda_lo)))
            |-> (st == E_START || st == E_STOP));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/clksyn_i2c_init.sv
// Run sequencer: walks the table, wrapping each register burst in start/addr/stop,
// aborts with a stop on any missing acknowledge. Assumes a single master on the bus.
module clksyn_i2c_init
    import clksyn_pkg::*;
#(
    parameter int QTR_CYCLES = 63,
    parameter int FB_MULT    = 32,
    parameter int OUT_DIV    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             load_we,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [7:0]       load_byte,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             busy,
    output logic             done,
    output logic             error
);
    typedef enum logic [2:0] {SQ_IDLE, SQ_START, SQ_ADDR, SQ_DATA, SQ_STOP} seq_st_t;

    seq_st_t          st;
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;
    logic             abort_q;
    logic             cmd_valid;
    bus_cmd_t         cmd;
    logic [7:0]       cmd_byte;
    logic             eng_done;
    logic             eng_nack;
    logic             last_here;

    // Data phase reads one entry ahead of the byte just sent.
    always_comb begin : p_rdsel
        rd_idx    = (st == SQ_DATA) ? IDX_W'(ptr + 1'b1) : ptr;
        last_here = is_last(int'(ptr));
    end

    clksyn_cfg_table #(.FB_MULT(FB_MULT), .OUT_DIV(OUT_DIV)) u_table (
        .clk(clk), .rst_n(rst_n), .lock(busy),
        .load_we(load_we), .load_idx(load_idx), .load_byte(load_byte),
        .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    clksyn_bit_engine #(.QTR_CYCLES(QTR_CYCLES)) u_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .cmd_byte(cmd_byte), .sda_in(sda_in), .done(eng_done), .nack(eng_nack),
        .scl_lo(scl_drive_low), .sda_lo(sda_drive_low)
    );

    // Issue the next bus command each time the engine finishes one.
    always_ff @(posedge clk) begin : p_seq
        if (!rst_n) begin
            st        <= SQ_IDLE;
            ptr       <= '0;
            abort_q   <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            error     <= 1'b0;
            cmd_valid <= 1'b0;
            cmd       <= BC_START;
            cmd_byte  <= 8'h00;
        end else begin
            cmd_valid <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    busy <= 1'b1; done <= 1'b0; error <= 1'b0;
                    abort_q <= 1'b0; ptr <= '0;
                    cmd_valid <= 1'b1; cmd <= BC_START;
                    st <= SQ_START;
                end
                SQ_START: if (eng_done) begin
                    cmd_valid <= 1'b1; cmd <= BC_WRITE; cmd_byte <= DEV_WR;
                    st <= SQ_ADDR;
                end
                SQ_ADDR: if (eng_done) begin
                    cmd_valid <= 1'b1;
                    if (eng_nack) begin
                        abort_q <= 1'b1; cmd <= BC_STOP; st <= SQ_STOP;
                    end else begin
                        cmd <= BC_WRITE; cmd_byte <= rd_byte; st <= SQ_DATA;
                    end
                end
                SQ_DATA: if (eng_done) begin
                    cmd_valid <= 1'b1;
                    if (eng_nack) begin
                        abort_q <= 1'b1; cmd <= BC_STOP; st <= SQ_STOP;
                    end else begin
                        ptr <= IDX_W'(ptr + 1'b1);
                        if (last_here) begin
                            cmd <= BC_STOP; st <= SQ_STOP;
                        end else begin
                            cmd <= BC_WRITE; cmd_byte <= rd_byte;
                        end
                    end
                end
                SQ_STOP: if (eng_done) begin
                    if (abort_q) begin
                        error <= 1'b1; busy <= 1'b0; st <= SQ_IDLE;
                    end else if (ptr == IDX_W'(TBL_LEN)) begin
                        done <= 1'b1; busy <= 1'b0; st <= SQ_IDLE;
                    end else begin
                        cmd_valid <= 1'b1; cmd <= BC_START; st <= SQ_START;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_err_after_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(abort_q));

    assert_done_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(ptr) == IDX_W'(TBL_LEN)));

    assert_busy_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !error));

endmodule

// File: tb/sim_clksyn_i2c_init.sv
// Bench: behavioural bus slave recording a register image, per-clock line checks.
module sim_clksyn_i2c_init;
    localparam int QTR   = 4;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, start = 1'b0, load_we = 1'b0;
    logic [4:0] load_idx = '0;
    logic [7:0] load_byte = '0;
    logic       scl_dl, sda_dl, busy, done, error;
    logic       slv_ack = 1'b0;
    wire        scl_w = !scl_dl;
    wire        sda_w = !(sda_dl || slv_ack);

    clksyn_i2c_init #(.QTR_CYCLES(QTR)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .load_we(load_we),
        .load_idx(load_idx), .load_byte(load_byte), .sda_in(sda_w),
        .scl_drive_low(scl_dl), .sda_drive_low(sda_dl),
        .busy(busy), .done(done), .error(error)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [7:0] img [256];
    int order_q [$];
    int starts, stops, bad_addr, gbyte, nack_at, bitc, kbyte, rise_t, hi_bad, hi_cnt, idle_bad;
    logic ack_phase, in_txn, rise_ok, pscl, psda;
    logic [7:0] sh, rptr;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Slave model and per-clock line checks, sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            pscl = 1'b1; psda = 1'b1; in_txn = 1'b0; rise_ok = 1'b0;
            ack_phase = 1'b0; slv_ack = 1'b0; bitc = 0;
        end else begin
            if (!busy && (!scl_w || !sda_w)) idle_bad++;
            if (pscl && scl_w && psda && !sda_w) begin
                starts++; bitc = 0; kbyte = 0; ack_phase = 1'b0; in_txn = 1'b1;
            end else if (pscl && scl_w && !psda && sda_w) begin
                stops++; in_txn = 1'b0; rise_ok = 1'b0;
            end else if (!pscl && scl_w) begin
                if (in_txn) begin rise_t = cyc; rise_ok = 1'b1; end
                if (bitc < 8) begin sh = {sh[6:0], sda_w}; bitc++; end
            end else if (pscl && !scl_w) begin
                if (rise_ok && in_txn) begin
                    hi_cnt++;
                    if (cyc - rise_t != 2 * QTR) hi_bad++;
                end
                rise_ok = 1'b0;
                if (ack_phase) begin
                    slv_ack = 1'b0; ack_phase = 1'b0; bitc = 0;
                end else if (bitc == 8) begin
                    ack_phase = 1'b1;
                    if (gbyte == nack_at) slv_ack = 1'b0;
                    else begin
                        slv_ack = 1'b1;
                        if (kbyte == 0) begin if (sh != 8'hC0) bad_addr++; end
                        else if (kbyte == 1) begin rptr = sh; order_q.push_back(int'(sh)); end
                        else begin img[rptr] = sh; rptr = rptr + 8'd1; end
                    end
                    gbyte++; kbyte++;
                end
            end
            pscl = scl_w; psda = sda_w;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_slave(input int nk);
        for (int i = 0; i < 256; i++) img[i] = 8'hEE;
        order_q.delete();
        starts = 0; stops = 0; bad_addr = 0; gbyte = 0; hi_bad = 0; hi_cnt = 0;
        idle_bad = 0; nack_at = nk;
    endtask

    task automatic launch(input int nk);
        @(negedge clk);
        clear_slave(nk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy after start", int'(busy), 1);
    endtask

    task automatic wait_idle();
        while (busy && cyc < LIMIT) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic load(input int idx, input int val);
        @(negedge clk);
        load_we = 1'b1; load_idx = 5'(idx); load_byte = 8'(val);
        @(negedge clk);
        load_we = 1'b0;
    endtask

    function automatic int p1(input int n);
        return 128 * n - 512;
    endfunction

    // Check an 8-byte integer-mode block: P3=1, P1 packed into bytes 2..4 (R5).
    task automatic chk_block(input string req, input int base, input int p, input int d4);
        chk(req, "blk byte0", int'(img[base]),     0);
        chk(req, "blk byte1", int'(img[base + 1]), 1);
        chk(req, "blk byte2", int'(img[base + 2]), (d4 << 2) | ((p >> 16) & 3));
        chk(req, "blk byte3", int'(img[base + 3]), (p >> 8) & 255);
        chk(req, "blk byte4", int'(img[base + 4]), p & 255);
        for (int k = 5; k < 8; k++) chk(req, "blk tail", int'(img[base + k]), 0);
    endtask

    initial begin
        clear_slave(-1);
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1", "busy at reset", int'(busy), 0);
        chk("R1", "done at reset", int'(done), 0);
        chk("R1", "error at reset", int'(error), 0);
        chk("R1", "scl released", int'(scl_w), 1);
        chk("R1", "sda released", int'(sda_w), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Run A: default plan
        launch(-1);
        wait_idle();
        chk("R9", "done after run", int'(done), 1);
        chk("R9", "error after run", int'(error), 0);
        chk("R2", "starts", starts, 4);
        chk("R2", "stops", stops, 4);
        chk("R2", "device byte errors", bad_addr, 0);
        chk("R3", "txn count", order_q.size(), 4);
        if (order_q.size() == 4) begin
            chk("R3", "txn0 reg", order_q[0], 8'h1A);
            chk("R3", "txn1 reg", order_q[1], 8'h2A);
            chk("R3", "txn2 reg", order_q[2], 8'hB1);
            chk("R3", "txn3 reg", order_q[3], 8'h10);
        end
        chk_block("R4", 8'h1A, p1(32), 0);
        chk_block("R4", 8'h2A, 0, 3);
        chk("R4", "pll reset", int'(img[8'hB1]), 8'h20);
        chk("R4", "out0 ctrl", int'(img[8'h10]), 8'h4F);
        chk("R7", "scl high pulses seen", int'(hi_cnt > 100), 1);
        chk("R7", "scl high width errors", hi_bad, 0);
        chk("R1", "lines while idle", idle_bad, 0);
        repeat (20) @(negedge clk);
        chk("R9", "done held", int'(done), 1);

        // Run B: retune output 0 to divide by 16
        load(12, 0);
        load(13, (p1(16) >> 8) & 255);
        load(14, p1(16) & 255);
        launch(-1);
        wait_idle();
        chk_block("R5", 8'h2A, p1(16), 0);
        chk_block("R6", 8'h1A, p1(32), 0);

        // Run C: load and second start while busy are ignored
        launch(-1);
        repeat (50) @(negedge clk);
        load(13, 8'h55);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_idle();
        chk("R6", "load while busy ignored", int'(img[8'h2D]), 8'h06);
        chk("R9", "start while busy ignored", starts, 4);

        // Run D: no ACK on address phase of third transaction (byte 20)
        launch(20);
        wait_idle();
        chk("R8", "error", int'(error), 1);
        chk("R8", "done low", int'(done), 0);
        chk("R8", "starts", starts, 3);
        chk("R8", "stops", stops, 3);
        chk("R8", "no pll reset", int'(img[8'hB1]), 8'hEE);
        chk("R8", "no out ctrl", int'(img[8'h10]), 8'hEE);
        chk("R6", "divider still loaded value", int'(img[8'h2D]), 8'h06);
        chk("R1", "lines while idle", idle_bad, 0);

        // Run E: no ACK on a data byte inside the first burst (byte 4)
        launch(4);
        wait_idle();
        chk("R8", "error mid burst", int'(error), 1);
        chk("R8", "bytes before nack", int'(img[8'h1B]), 8'h01);
        chk("R8", "nacked byte", int'(img[8'h1C]), 8'hEE);
        chk("R8", "no second txn", int'(img[8'h2A]), 8'hEE);
        chk("R8", "stop issued", stops, 1);

        // Run F: recovery
        launch(-1);
        wait_idle();
        chk("R9", "error cleared", int'(error), 0);
        chk("R9", "done again", int'(done), 1);
        chk("R7", "scl high width errors", hi_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule